// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a parallel NOR-style flash and turns sequences of host write cycles into single commands. Each host write shows up as a one-cycle `wrValid` pulse that carries an address and a data word. The block matches these writes against keyed unlock sequences whose addresses are checked. When a sequence completes, it raises a one-cycle strobe for program, chip erase, sector erase, autoselect entry, reset, bypass entry, bypass exit, erase suspend or erase resume. Alongside the strobe it latches the operand address and data of that final write.

The block also tracks a mode that shapes how later writes are read. The modes are array read, identification (autoselect), fast-program bypass and erase-suspended. An external program/erase engine reports `engineBusy` and `eraseActive`, and the decoder uses these to gate which commands it accepts. The array, the operation timing and the status bits are not part of this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every command strobe is low and `mode` reads 0 (array read). The other `mode` codes are 1 for autoselect, 2 for bypass and 3 for erase-suspended. When several states hold, autoselect takes priority over bypass, and bypass over suspended.
- R2: In word mode (`byteMode`=0) a program takes four writes: AA to 555, then 55 to 2AA, then A0 to 555, then any address and data. Only the last 11 address bits and the low data byte are compared. The cycle after the fourth write, `cmdProgram` pulses for exactly one cycle, with `opAddr`/`opData` equal to that write's address and data.
- R3: In byte mode (`byteMode`=1) the unlock addresses are AAA and 555, and only the low 12 address bits are compared. Sequences otherwise behave as in word mode.
- R4: An erase is the two unlock writes, 80 at the first unlock address, and the two unlock writes again. A sixth write of 10 at the first unlock address pulses `cmdChipErase`. A sixth write of 30 at any other address pulses `cmdSectorErase` with that address in `opAddr`. A sixth write of 10 at a non-unlock address issues nothing.
- R5: The two unlock writes followed by 90 at the first unlock address pulse `cmdAutoselect` and set mode 1. In mode 1 every write other than F0 is ignored. A write of F0 to any address (outside a program data cycle) pulses `cmdReset` and clears autoselect, which returns `mode` to 0, or to 3 if an erase is suspended.
- R6: The two unlock writes followed by 20 at the first unlock address pulse `cmdBypassEnter` and set mode 2. In mode 2, A0 to any address followed by one write pulses `cmdProgram` with that write's operands. A write of 90 followed by 00 pulses `cmdBypassExit` and leaves mode 2. A write of 90 followed by any other value does nothing.
- R7: B0 to any address pulses `cmdSuspend` only when `eraseActive` is high and no suspend is pending, and then sets mode 3. `opAddr` carries the write address, and its top two bits are the bank. Otherwise B0 is ignored.
- R8: While suspended, 30 written in the idle state pulses `cmdResume` and clears the suspended state. When nothing is suspended, that write does nothing.
- R9: A write that does not match the next expected step aborts the sequence without any strobe, and the next write is decoded from the start. A strobe only ever follows a write.
- R10: While `engineBusy` is high, every write except a legal suspend is ignored. This includes reset and program sequences.
- R11: While an erase is suspended, the erase setup byte 80 is rejected, so a complete erase sequence issues no erase strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One-cycle pulse marking a host write |
| wrAddr | input | 18 | Host write address (top 2 bits are the bank) |
| wrData | input | 16 | Host write data |
| byteMode | input | 1 | 1 selects byte addressing for the unlock addresses |
| engineBusy | input | 1 | External engine is running a program or erase |
| eraseActive | input | 1 | External engine is running a sector erase |
| cmdProgram | output | 1 | Program strobe |
| cmdChipErase | output | 1 | Chip erase strobe |
| cmdSectorErase | output | 1 | Sector erase strobe |
| cmdAutoselect | output | 1 | Autoselect entry strobe |
| cmdReset | output | 1 | Reset strobe |
| cmdBypassEnter | output | 1 | Bypass entry strobe |
| cmdBypassExit | output | 1 | Bypass exit strobe |
| cmdSuspend | output | 1 | Erase suspend strobe |
| cmdResume | output | 1 | Erase resume strobe |
| opAddr | output | 18 | Address of the write that completed the last command |
| opData | output | 16 | Data of the write that completed the last command |
| mode | output | 2 | 0 read, 1 autoselect, 2 bypass, 3 erase-suspended |

## Verification
The program sequence is swept over several addresses and data values in both addressing modes. Junk is placed in the ignored high address and data bits, which shows whether the decoder compares only the bits it should. An abort sweep corrupts each unlock and command step in turn, by wrong data and by wrong address. This separates a decoder that resynchronises cleanly from one that leaks strobes or stays stuck mid-sequence. Mode-dependent runs cover autoselect, bypass, suspend and busy, and they tell apart gating by the mode flags from gating by the engine inputs.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int UNL_W = 11;
  localparam logic [UNL_W-1:0] UNL_FIRST  = 11'h555;
  localparam logic [UNL_W-1:0] UNL_SECOND = 11'h2AA;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_BYPASS  = 8'h20;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_BPEXIT  = 8'h00;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_PROGRAM, CMD_CHIP, CMD_SECTOR, CMD_AUTOSEL,
    CMD_RESET, CMD_BP_ENTER, CMD_BP_EXIT, CMD_SUSPEND, CMD_RESUME
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0, MODE_AUTO = 2'd1, MODE_BYPASS = 2'd2, MODE_SUSP = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3,
    ST_BP_PROG, ST_BP_EXIT
  } seq_e;

  typedef struct packed {
    cmd_e cmd;
    logic setAuto;
    logic clrAuto;
    logic setBypass;
    logic clrBypass;
    logic setSusp;
    logic clrSusp;
  } ctl_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       isUnlockA,
  input  logic       isUnlockB,
  input  logic [7:0] cmdByte,
  input  logic       engineBusy,
  input  logic       eraseActive,
  input  logic       autoQ,
  input  logic       bypassQ,
  input  logic       suspQ,
  output ctl_t       ctl
);
  seq_e state, stateNext;
  logic dataPhase;

  assign dataPhase = (state == ST_PROG) || (state == ST_BP_PROG);

  always_comb begin
    ctl       = '0;
    ctl.cmd   = CMD_NONE;
    stateNext = state;
    if (wrValid) begin
      stateNext = ST_IDLE;
      if (!dataPhase && cmdByte == OP_SUSPEND) begin
        if (eraseActive && !suspQ) begin
          ctl.cmd     = CMD_SUSPEND;
          ctl.setSusp = 1'b1;
        end
      end else if (engineBusy) begin
        stateNext = ST_IDLE;
      end else if (!dataPhase && cmdByte == OP_RESET) begin
        ctl.cmd     = CMD_RESET;
        ctl.clrAuto = 1'b1;
      end else if (!autoQ) begin
        unique case (state)
          ST_IDLE: begin
            if (suspQ && cmdByte == OP_SECTOR) begin
              ctl.cmd     = CMD_RESUME;
              ctl.clrSusp = 1'b1;
            end else if (bypassQ) begin
              if (cmdByte == OP_PROG)       stateNext = ST_BP_PROG;
              else if (cmdByte == OP_IDENT) stateNext = ST_BP_EXIT;
            end else if (cmdByte == KEY_A && isUnlockA) begin
              stateNext = ST_UNL1;
            end
          end
          ST_UNL1: if (cmdByte == KEY_B && isUnlockB) stateNext = ST_UNL2;
          ST_UNL2: begin
            if (isUnlockA) begin
              if (cmdByte == OP_PROG) stateNext = ST_PROG;
              else if (cmdByte == OP_IDENT) begin
                ctl.cmd     = CMD_AUTOSEL;
                ctl.setAuto = 1'b1;
              end else if (cmdByte == OP_ERASE && !suspQ) stateNext = ST_ERS1;
              else if (cmdByte == OP_BYPASS) begin
                ctl.cmd       = CMD_BP_ENTER;
                ctl.setBypass = 1'b1;
              end
            end
          end
          ST_PROG:    ctl.cmd = CMD_PROGRAM;
          ST_BP_PROG: ctl.cmd = CMD_PROGRAM;
          ST_ERS1: if (cmdByte == KEY_A && isUnlockA) stateNext = ST_ERS2;
          ST_ERS2: if (cmdByte == KEY_B && isUnlockB) stateNext = ST_ERS3;
          ST_ERS3: begin
            if (cmdByte == OP_CHIP && isUnlockA) ctl.cmd = CMD_CHIP;
            else if (cmdByte == OP_SECTOR)       ctl.cmd = CMD_SECTOR;
          end
          ST_BP_EXIT: begin
            if (cmdByte == OP_BPEXIT) begin
              ctl.cmd       = CMD_BP_EXIT;
              ctl.clrBypass = 1'b1;
            end
          end
          default: stateNext = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !wrValid) |=> (state == ST_IDLE)); // R9
endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteMode,
  input  logic              engineBusy,
  input  logic              eraseActive,
  input  ctl_t              ctl,
  output logic              isUnlockA,
  output logic              isUnlockB,
  output logic [7:0]        cmdByte,
  output logic              autoQ,
  output logic              bypassQ,
  output logic              suspQ,
  output logic              cmdProgram,
  output logic              cmdChipErase,
  output logic              cmdSectorErase,
  output logic              cmdAutoselect,
  output logic              cmdReset,
  output logic              cmdBypassEnter,
  output logic              cmdBypassExit,
  output logic              cmdSuspend,
  output logic              cmdResume,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [1:0]        mode
);
  localparam int BYTE_W = UNL_W + 1;

  cmd_e cmdQ;

  assign cmdByte = wrData[7:0];

  always_comb begin
    if (byteMode) begin
      isUnlockA = (wrAddr[BYTE_W-1:0] == {UNL_FIRST, 1'b0});
      isUnlockB = (wrAddr[BYTE_W-1:0] == {UNL_SECOND, 1'b1});
    end else begin
      isUnlockA = (wrAddr[UNL_W-1:0] == UNL_FIRST);
      isUnlockB = (wrAddr[UNL_W-1:0] == UNL_SECOND);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ    <= CMD_NONE;
      opAddr  <= '0;
      opData  <= '0;
      autoQ   <= 1'b0;
      bypassQ <= 1'b0;
      suspQ   <= 1'b0;
    end else begin
      cmdQ <= ctl.cmd;
      if (ctl.cmd != CMD_NONE) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
      if (ctl.setAuto)        autoQ   <= 1'b1;
      else if (ctl.clrAuto)   autoQ   <= 1'b0;
      if (ctl.setBypass)      bypassQ <= 1'b1;
      else if (ctl.clrBypass) bypassQ <= 1'b0;
      if (ctl.setSusp)        suspQ   <= 1'b1;
      else if (ctl.clrSusp)   suspQ   <= 1'b0;
    end
  end

  assign cmdProgram     = (cmdQ == CMD_PROGRAM);
  assign cmdChipErase   = (cmdQ == CMD_CHIP);
  assign cmdSectorErase = (cmdQ == CMD_SECTOR);
  assign cmdAutoselect  = (cmdQ == CMD_AUTOSEL);
  assign cmdReset       = (cmdQ == CMD_RESET);
  assign cmdBypassEnter = (cmdQ == CMD_BP_ENTER);
  assign cmdBypassExit  = (cmdQ == CMD_BP_EXIT);
  assign cmdSuspend     = (cmdQ == CMD_SUSPEND);
  assign cmdResume      = (cmdQ == CMD_RESUME);

  always_comb begin
    if (autoQ)        mode = MODE_AUTO;
    else if (bypassQ) mode = MODE_BYPASS;
    else if (suspQ)   mode = MODE_SUSP;
    else              mode = MODE_READ;
  end

  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NONE) |-> $past(wrValid)); // R9
  AST_BUSY_NO_WORK: assert property (@(posedge clk) disable iff (!rstN)
    $past(engineBusy) |-> !(cmdProgram || cmdChipErase || cmdSectorErase)); // R10
  AST_SUSPEND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cmdSuspend |-> ($past(eraseActive) && !$past(suspQ))); // R7
  AST_RESUME_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cmdResume |-> ($past(suspQ) && !suspQ)); // R8
  AST_AUTO_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(autoQ) |-> cmdReset); // R5
  AST_BYPASS_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bypassQ) |-> cmdBypassExit); // R6
  AST_NO_ERASE_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdChipErase || cmdSectorErase) |-> !$past(suspQ)); // R11
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteMode,
  input  logic              engineBusy,
  input  logic              eraseActive,
  output logic              cmdProgram,
  output logic              cmdChipErase,
  output logic              cmdSectorErase,
  output logic              cmdAutoselect,
  output logic              cmdReset,
  output logic              cmdBypassEnter,
  output logic              cmdBypassExit,
  output logic              cmdSuspend,
  output logic              cmdResume,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [1:0]        mode
);
  ctl_t       ctl;
  logic       isUnlockA, isUnlockB;
  logic [7:0] cmdByte;
  logic       autoQ, bypassQ, suspQ;

  fcd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .isUnlockA(isUnlockA), .isUnlockB(isUnlockB), .cmdByte(cmdByte),
    .engineBusy(engineBusy), .eraseActive(eraseActive),
    .autoQ(autoQ), .bypassQ(bypassQ), .suspQ(suspQ), .ctl(ctl)
  );

  fcd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .byteMode(byteMode), .engineBusy(engineBusy),
    .eraseActive(eraseActive), .ctl(ctl),
    .isUnlockA(isUnlockA), .isUnlockB(isUnlockB), .cmdByte(cmdByte),
    .autoQ(autoQ), .bypassQ(bypassQ), .suspQ(suspQ),
    .cmdProgram(cmdProgram), .cmdChipErase(cmdChipErase),
    .cmdSectorErase(cmdSectorErase), .cmdAutoselect(cmdAutoselect),
    .cmdReset(cmdReset), .cmdBypassEnter(cmdBypassEnter),
    .cmdBypassExit(cmdBypassExit), .cmdSuspend(cmdSuspend),
    .cmdResume(cmdResume), .opAddr(opAddr), .opData(opData), .mode(mode)
  );
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [17:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        byteMode = 1'b0;
  logic        engineBusy = 1'b0;
  logic        eraseActive = 1'b0;
  logic cmdProgram, cmdChipErase, cmdSectorErase, cmdAutoselect, cmdReset;
  logic cmdBypassEnter, cmdBypassExit, cmdSuspend, cmdResume;
  logic [17:0] opAddr;
  logic [15:0] opData;
  logic [1:0]  mode;
  logic [8:0]  strb;

  int checks = 0;
  int fails = 0;

  // strobe bit positions
  localparam int S_PRG = 8, S_CHP = 7, S_SEC = 6, S_AUT = 5, S_RST = 4;
  localparam int S_BPI = 3, S_BPO = 2, S_SUS = 1, S_RES = 0, S_NONE = -1;

  always #5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .byteMode(byteMode), .engineBusy(engineBusy),
    .eraseActive(eraseActive), .cmdProgram(cmdProgram),
    .cmdChipErase(cmdChipErase), .cmdSectorErase(cmdSectorErase),
    .cmdAutoselect(cmdAutoselect), .cmdReset(cmdReset),
    .cmdBypassEnter(cmdBypassEnter), .cmdBypassExit(cmdBypassExit),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume),
    .opAddr(opAddr), .opData(opData), .mode(mode)
  );

  assign strb = {cmdProgram, cmdChipErase, cmdSectorErase, cmdAutoselect,
                 cmdReset, cmdBypassEnter, cmdBypassExit, cmdSuspend, cmdResume};

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expS(input int idx, input string tag);
    logic [8:0] e;
    e = (idx < 0) ? 9'd0 : (9'd1 << idx);
    chk(strb == e, tag, 32'(strb), 32'(e));
  endtask

  task automatic expM(input logic [1:0] m, input string tag);
    chk(mode == m, tag, 32'(mode), 32'(m));
  endtask

  // one write; returns at the negedge where the resulting strobe is visible
  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  function automatic logic [17:0] junk(input bit bm, input int j);
    if (bm) return 18'(((j * 37) & 6'h3F) << 12);
    return 18'(((j * 37) & 7'h7F) << 11);
  endfunction

  function automatic logic [17:0] ua(input bit bm, input int j);
    return junk(bm, j) | (bm ? 18'hAAA : 18'h555);
  endfunction

  function automatic logic [17:0] ub(input bit bm, input int j);
    return junk(bm, j) | (bm ? 18'h555 : 18'h2AA);
  endfunction

  function automatic logic [15:0] dj(input int j, input logic [7:0] b);
    return {8'(j * 11 + 3), b};
  endfunction

  task automatic unlock(input bit bm, input int j);
    wr(ua(bm, j), dj(j, 8'hAA));
    wr(ub(bm, j), dj(j, 8'h55));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expS(S_NONE, "R1 reset strobes");
    expM(2'd0, "R1 reset mode");

    // program sweep in both addressing modes (R2 word, R3 byte)
    for (int bm = 0; bm < 2; bm++) begin
      byteMode = bm[0];
      for (int k = 0; k < 6; k++) begin
        logic [17:0] pa;
        logic [15:0] pd;
        pa = 18'((k * 18'h0B3D7 + bm * 2) & 18'h3FFFF);
        pd = 16'(k * 16'h1357 + 16'h2468);
        unlock(bm[0], k);
        wr(ua(bm[0], k), dj(k, 8'hA0));
        expS(S_NONE, bm ? "R3 no strobe before data" : "R2 no strobe before data");
        wr(pa, pd);
        expS(S_PRG, bm ? "R3 program strobe" : "R2 program strobe");
        chk(opAddr == pa, "R2 opAddr", 32'(opAddr), 32'(pa));
        chk(opData == pd, "R2 opData", 32'(opData), 32'(pd));
        @(negedge clk);
        expS(S_NONE, "R2 strobe lasts one cycle");
      end
    end
    byteMode = 1'b0;

    // word-mode addresses rejected in byte mode
    byteMode = 1'b1;
    wr(18'h555, 16'hAA); wr(18'h2AA, 16'h55); wr(18'h555, 16'hA0); wr(18'h123, 16'h9);
    expS(S_NONE, "R3 word addresses rejected in byte mode");
    byteMode = 1'b0;

    // abort sweep: corrupt each of the first three steps (R9)
    for (int s = 0; s < 3; s++) begin
      for (int how = 0; how < 2; how++) begin
        for (int st = 0; st < 4; st++) begin
          logic [17:0] a;
          logic [7:0]  b;
          a = (st == 1) ? ub(0, st) : ua(0, st);
          b = (st == 0) ? 8'hAA : (st == 1) ? 8'h55 : 8'hA0;
          if (st == 3) begin
            wr(18'h0777, 16'h4242);
          end else if (st == s) begin
            if (how == 0) wr(a, {8'h00, 8'h5A});
            else          wr(a ^ 18'h001, {8'h00, b});
          end else begin
            wr(a, {8'h00, b});
          end
          expS(S_NONE, "R9 aborted sequence gives no strobe");
        end
        unlock(0, s);
        wr(ua(0, s), 16'hA0);
        wr(18'h00100, 16'hBEEF);
        expS(S_PRG, "R9 clean sequence after abort");
      end
    end

    // erase in both modes (R4)
    for (int bm = 0; bm < 2; bm++) begin
      byteMode = bm[0];
      unlock(bm[0], 5); wr(ua(bm[0], 5), 16'h80); unlock(bm[0], 6);
      wr(ua(bm[0], 7), 16'h10);
      expS(S_CHP, "R4 chip erase");
      unlock(bm[0], 1); wr(ua(bm[0], 1), 16'h80); unlock(bm[0], 2);
      wr(18'h2C000, 16'h30);
      expS(S_SEC, "R4 sector erase");
      chk(opAddr == 18'h2C000, "R4 sector address", 32'(opAddr), 32'h2C000);
      unlock(bm[0], 3); wr(ua(bm[0], 3), 16'h80); unlock(bm[0], 4);
      wr(18'h01234, 16'h10);
      expS(S_NONE, "R4 chip code at non-unlock address");
    end
    byteMode = 1'b0;

    // autoselect (R5)
    unlock(0, 9); wr(ua(0, 9), 16'h90);
    expS(S_AUT, "R5 autoselect strobe");
    expM(2'd1, "R5 autoselect mode");
    unlock(0, 9); wr(ua(0, 9), 16'hA0); wr(18'h00010, 16'h1111);
    expS(S_NONE, "R5 writes ignored in autoselect");
    expM(2'd1, "R5 autoselect persists");
    wr(18'h3ABCD, 16'h77F0);
    expS(S_RST, "R5 reset strobe");
    expM(2'd0, "R5 reset returns to read");

    // bypass (R6)
    unlock(0, 2); wr(ua(0, 2), 16'h20);
    expS(S_BPI, "R6 bypass enter");
    expM(2'd2, "R6 bypass mode");
    for (int k = 0; k < 4; k++) begin
      logic [17:0] pa;
      pa = 18'(k * 18'h09001 + 18'h00040);
      wr(18'(k * 18'h1111), 16'hA0);
      expS(S_NONE, "R6 no strobe on bypass A0");
      wr(pa, 16'(k + 16'h5000));
      expS(S_PRG, "R6 bypass program");
      chk(opAddr == pa, "R6 bypass opAddr", 32'(opAddr), 32'(pa));
    end
    wr(18'h0, 16'h90); wr(18'h0, 16'h01);
    expS(S_NONE, "R6 wrong exit code ignored");
    expM(2'd2, "R6 still bypass");
    wr(18'h5, 16'h90); wr(18'h9, 16'h00);
    expS(S_BPO, "R6 bypass exit");
    expM(2'd0, "R6 back to read");

    // suspend / resume (R7, R8, R11)
    wr(18'h20000, 16'hB0);
    expS(S_NONE, "R7 suspend ignored without erase");
    wr(18'h00000, 16'h30);
    expS(S_NONE, "R8 resume ignored when not suspended");
    eraseActive = 1'b1;
    wr(18'h2F00F, 16'hB0);
    expS(S_SUS, "R7 suspend strobe");
    chk(opAddr[17:16] == 2'b10, "R7 bank in opAddr", 32'(opAddr[17:16]), 32'h2);
    expM(2'd3, "R7 suspended mode");
    wr(18'h10000, 16'hB0);
    expS(S_NONE, "R7 second suspend ignored");
    unlock(0, 4); wr(ua(0, 4), 16'h80); unlock(0, 4); wr(ua(0, 4), 16'h10);
    expS(S_NONE, "R11 erase rejected while suspended");
    unlock(0, 8); wr(ua(0, 8), 16'hA0); wr(18'h00444, 16'h0A0A);
    expS(S_PRG, "R11 program allowed while suspended");
    unlock(0, 8); wr(ua(0, 8), 16'h90);
    expM(2'd1, "R5 autoselect over suspend");
    wr(18'h0, 16'hF0);
    expS(S_RST, "R5 reset in suspend");
    expM(2'd3, "R5 reset returns to suspended");
    wr(18'h10000, 16'h30);
    expS(S_RES, "R8 resume strobe");
    expM(2'd0, "R8 resume clears suspend");

    // busy gating (R10)
    engineBusy = 1'b1;
    unlock(0, 3); wr(ua(0, 3), 16'hA0); wr(18'h00222, 16'h3333);
    expS(S_NONE, "R10 program ignored while busy");
    wr(18'h0, 16'hF0);
    expS(S_NONE, "R10 reset ignored while busy");
    wr(18'h1ABCD, 16'hB0);
    expS(S_SUS, "R10 suspend accepted while busy");
    expM(2'd3, "R10 mode after busy suspend");
    engineBusy = 1'b0;
    wr(18'h10000, 16'h30);
    expS(S_RES, "R10 resume after busy");
    eraseActive = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule